// File: doc/BRIEF.md
# On-Demand Serial Word Transmitter

This block sends words over a synchronous serial link only when the host supplies them. There is no periodic frame and there are no time slots. The host writes a word into a single holding register through a one-cycle write strobe. On the next rising edge of the internal bit clock, the word moves into a shift register and is sent most significant bit first. The block drives three outputs: a serial clock, serial data and a frame sync.

Two clocking styles are supported.
- **Gated:** the serial clock pulses only while a word's bits are on the line.
- **Continuous:** the clock runs all the time, and a one-bit-period frame sync pulse marks the first bit of each word.

After every word the block forces a two-bit-period idle gap. This keeps consecutive words apart in either style. Because a transfer is only ever started by data, an underrun cannot occur and no underrun indication exists. The word length is chosen by a two-bit selector. The bit rate comes from an 8-bit divider setting.

Top module: `odsx_tx`

## Requirements
- R1: While reset is asserted and after its release, before any write: `tx_empty`=1, `wr_collision`=0, `sdata`=0 and `fsync`=0. In gated mode `sclk`=0.
- R2: With no write accepted, gated mode produces no `sclk` rising edge and `fsync` stays 0.
- R3: The internal bit clock toggles every `cfg_div`+1 system cycles, so one bit period is 2×(`cfg_div`+1) cycles. In continuous mode (`cfg_gated`=0) `sclk` follows it at all times.
- R4: `cfg_wsel` selects the word length: 2'b00 = 8 bits, 2'b01 = 12, 2'b10 = 16, 2'b11 = 24. The word is right-justified in `wr_data`, so its first bit sent is bit (length−1).
- R5: Bits leave most significant first. `sdata` changes together with the rising edge of `sclk` and holds through the following falling edge.
- R6: `fsync` is 1 for exactly the first bit period of each word sent and is 0 otherwise.
- R7: In gated mode (`cfg_gated`=1), `sclk` pulses exactly once per bit of a word and is 0 at all other times.
- R8: After the last bit of a word, two complete bit periods pass before the next word can start, even when a word is already waiting.
- R9: `tx_empty` becomes 1 in the cycle after the holding register's word moves into the shift register. A write is accepted only while `tx_empty`=1, so at most one word waits.
- R10: A write while `tx_empty`=0 is discarded: the waiting word is not altered and is the one sent. The write sets `wr_collision`, which stays 1 until reset.
- R11: `sdata` is 0 whenever no word is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gated | input | 1 | 1 = gated clock, 0 = continuous clock |
| cfg_wsel | input | 2 | Word length select |
| cfg_div | input | DIV_W | Half bit period minus one, in system cycles |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | WORD_W | Word to send, right-justified |
| tx_empty | output | 1 | Holding register free |
| wr_collision | output | 1 | Sticky flag for a write that was ignored |
| sclk | output | 1 | Serial bit clock |
| sdata | output | 1 | Serial data |
| fsync | output | 1 | Frame sync, first bit period of a word |

## Verification
The hardest case to reach from the ports is a word that is already waiting when the previous word ends. Only then does the forced two-period gap, rather than host latency, set the spacing.

The stimulus gets there by writing the next word as soon as `tx_empty` rises, which is during the first bit of the current word. It then measures the distance between serial clock pulses across the word boundary.

A second hard case is a write that lands between acceptance and transfer. The stimulus produces it by issuing two writes on consecutive cycles. It then checks the sticky flag and that the first word, not the second, is the one that appears on the line.

// File: rtl/odsx_pkg.sv
package odsx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } tx_state_t;

  // word length in bits for a length selector
  function automatic logic [4:0] wlen_bits(input logic [1:0] sel);
    logic [4:0] n;
    case (sel)
      2'b00:   n = 5'd8;
      2'b01:   n = 5'd12;
      2'b10:   n = 5'd16;
      default: n = 5'd24;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/odsx_bitclk.sv
module odsx_bitclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             phase,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             tick;

  assign tick = (cnt_q >= div);
  assign rise = tick & ~ph_q;
  assign fall = tick & ph_q;
  assign phase = ph_q;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    ph_d  = ph_q;
    if (tick) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  // phase only moves on a divider terminal count
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ph_q));

endmodule

// File: rtl/odsx_hold.sv
module odsx_hold #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic [WORD_W-1:0] hold_data,
  output logic              hold_full,
  output logic              wr_collision
);

  logic [WORD_W-1:0] data_q, data_d;
  logic              full_q, full_d;
  logic              coll_q, coll_d;
  logic              accept;

  assign accept = wr_en & ~full_q;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    coll_d = coll_q | (wr_en & full_q);
    if (take)   full_d = 1'b0;
    if (accept) begin
      data_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      if (accept) data_q <= data_d;
      full_q <= full_d;
      coll_q <= coll_d;
    end
  end

  assign hold_data    = data_q;
  assign hold_full    = full_q;
  assign wr_collision = coll_q;

  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_q) |=> wr_collision);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collision |=> wr_collision);
  p_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_q) |=> $stable(data_q));

endmodule

// File: rtl/odsx_shift.sv
module odsx_shift
  import odsx_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic [1:0]        wsel,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] hold_data,
  output logic              take,
  output logic              active,
  output logic              sdata,
  output logic              fsync
);

  tx_state_t         st_q, st_d;
  logic [4:0]        bits_q, bits_d;
  logic              gap_q, gap_d;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              sd_q, sd_d;
  logic              fs_q, fs_d;
  logic              act_q, act_d;
  logic              start;
  logic [4:0]        wl;
  logic [WORD_W-1:0] aligned;

  assign wl      = wlen_bits(wsel);
  assign aligned = hold_data << (5'(WORD_W) - wl);

  always_comb begin
    st_d   = st_q;
    bits_d = bits_q;
    gap_d  = gap_q;
    sr_d   = sr_q;
    sd_d   = sd_q;
    fs_d   = fs_q;
    act_d  = act_q;
    start  = 1'b0;
    if (rise) begin
      case (st_q)
        ST_IDLE: start = hold_full;
        ST_SHIFT: begin
          fs_d = 1'b0;
          if (bits_q == 5'd0) begin
            st_d  = ST_GAP;
            gap_d = 1'b0;
            sd_d  = 1'b0;
            act_d = 1'b0;
          end else begin
            sr_d   = sr_q << 1;
            sd_d   = sr_q[WORD_W-2];
            bits_d = bits_q - 5'd1;
          end
        end
        ST_GAP: begin
          if (!gap_q) begin
            gap_d = 1'b1;
          end else begin
            start = hold_full;
            if (!hold_full) st_d = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (start) begin
        st_d   = ST_SHIFT;
        sr_d   = aligned;
        sd_d   = aligned[WORD_W-1];
        bits_d = wl - 5'd1;
        fs_d   = 1'b1;
        act_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bits_q <= '0;
      gap_q  <= 1'b0;
      sr_q   <= '0;
      sd_q   <= 1'b0;
      fs_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (rise) begin
      st_q   <= st_d;
      bits_q <= bits_d;
      gap_q  <= gap_d;
      sr_q   <= sr_d;
      sd_q   <= sd_d;
      fs_q   <= fs_d;
      act_q  <= act_d;
    end
  end

  assign take   = start;
  assign active = act_q;
  assign sdata  = sd_q;
  assign fsync  = fs_q;

  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SHIFT) |-> (!sd_q && !fs_q));
  p_fs_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && rise) |=> !fs_q);
  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && !gap_q) |-> !take);

endmodule

// File: rtl/odsx_tx.sv
module odsx_tx #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_gated,
  input  logic [1:0]        cfg_wsel,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              wr_collision,
  output logic              sclk,
  output logic              sdata,
  output logic              fsync
);

  logic              phase, rise, fall;
  logic              take, active, hold_full;
  logic [WORD_W-1:0] hold_data;

  odsx_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .div   (cfg_div),
    .phase (phase),
    .rise  (rise),
    .fall  (fall)
  );

  odsx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .take         (take),
    .hold_data    (hold_data),
    .hold_full    (hold_full),
    .wr_collision (wr_collision)
  );

  odsx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise),
    .wsel      (cfg_wsel),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .active    (active),
    .sdata     (sdata),
    .fsync     (fsync)
  );

  assign tx_empty = ~hold_full;
  assign sclk     = phase & (active | ~cfg_gated);

  p_gated_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gated && !active) |-> !sclk);
  p_empty_on_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tx_empty);
  p_no_clk_edge_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_gated && !fall) |=> !$fell(sclk));

endmodule

// File: tb/odsx_tx_test.sv
module odsx_tx_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_gated;
  logic [1:0]  cfg_wsel;
  logic [7:0]  cfg_div;
  logic        wr_en;
  logic [23:0] wr_data;
  logic        tx_empty, wr_collision, sclk, sdata, fsync;

  always #2.5 clk = ~clk;

  odsx_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_gated(cfg_gated), .cfg_wsel(cfg_wsel),
    .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
    .wr_collision(wr_collision), .sclk(sclk), .sdata(sdata), .fsync(fsync)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_st, m_gap;
  bit m_ph, m_act, m_sd, m_fs, m_full, m_coll;
  int m_hold;
  bit m_bits[$];

  function automatic int wl_of(input logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 12;
      2'b10: return 16;
      default: return 24;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_gap = 0; m_ph = 0; m_act = 0; m_sd = 0;
      m_fs = 0; m_full = 0; m_coll = 0; m_hold = 0; m_bits.delete();
    end else begin
      bit tick, rise, old_full, start;
      int wl;
      tick = (m_cnt >= cfg_div);
      rise = tick && !m_ph;
      old_full = m_full;
      start = 0;
      if (wr_en) begin
        if (!old_full) begin m_hold = wr_data; m_full = 1; end
        else m_coll = 1;
      end
      if (rise) begin
        if (m_st == 0) start = old_full;
        else if (m_st == 1) begin
          m_fs = 0;
          if (m_bits.size() == 0) begin
            m_st = 2; m_gap = 0; m_sd = 0; m_act = 0;
          end else m_sd = m_bits.pop_front();
        end else begin
          if (m_gap == 0) m_gap = 1;
          else begin start = old_full; if (!old_full) m_st = 0; end
        end
        if (start) begin
          wl = wl_of(cfg_wsel);
          m_full = 0; m_st = 1; m_fs = 1; m_act = 1;
          m_sd = m_hold[wl-1];
          for (int i = wl - 2; i >= 0; i--) m_bits.push_back(m_hold[i]);
        end
      end
      m_cnt = tick ? 0 : m_cnt + 1;
      if (tick) m_ph = !m_ph;
    end
  end

  // ---------------- per-clock comparison and edge bookkeeping ----------------
  bit  p_sclk = 0, p_fs = 0;
  int  pulses = 0, fs_rises = 0, fs_high = 0, last_rise = -1;
  int  cap = 0;
  bit  b2b = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit e_sclk;
      int period;
      e_sclk = m_ph && (m_act || !cfg_gated);
      period = 2 * (cfg_div + 1);
      check(sclk == e_sclk, "R3 R7 sclk", sclk, e_sclk);
      check(sdata == m_sd, "R5 R11 sdata", sdata, m_sd);
      check(fsync == m_fs, "R6 fsync", fsync, m_fs);
      check(tx_empty == !m_full, "R9 tx_empty", tx_empty, !m_full);
      check(wr_collision == m_coll, "R10 wr_collision", wr_collision, m_coll);
      if (sclk && !p_sclk) begin
        pulses++;
        cap = (cap << 1) | sdata;
        if (last_rise >= 0 && (!cfg_gated || !b2b))
          if (!cfg_gated) check(cyc - last_rise == period, "R3 spacing", cyc - last_rise, period);
        if (last_rise >= 0 && b2b && cyc - last_rise != period)
          check(cyc - last_rise == 3 * period, "R8 gap", cyc - last_rise, 3 * period);
        last_rise = cyc;
      end
      if (fsync && !p_fs) fs_rises++;
      if (fsync) fs_high++;
      p_sclk = sclk;
      p_fs = fsync;
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset(input bit g, input logic [1:0] ws, input logic [7:0] dv);
    @(negedge clk);
    rst_n = 0; wr_en = 0; wr_data = 0;
    cfg_gated = g; cfg_wsel = ws; cfg_div = dv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    pulses = 0; fs_rises = 0; fs_high = 0; last_rise = -1; cap = 0;
    p_sclk = 0; p_fs = 0; b2b = 0;
  endtask

  task automatic write_word(input int d);
    while (!tx_empty) @(negedge clk);
    wr_en = 1; wr_data = d[23:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle_wait();
    repeat (2 * (cfg_div + 1) * 30) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; cfg_gated = 1; cfg_wsel = 0; cfg_div = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    check(wr_collision == 0, "R1 wr_collision", wr_collision, 0);
    check(sclk == 0 && sdata == 0 && fsync == 0, "R1 lines", {sclk, sdata, fsync}, 0);

    // R2 no data, no clock in gated mode
    do_reset(1, 2'b11, 8'd1);
    repeat (80) @(negedge clk);
    check(pulses == 0, "R2 pulses idle", pulses, 0);
    check(fs_rises == 0, "R2 fsync idle", fs_rises, 0);

    // R4 R5 R6 R7 each word length, gated
    for (int ws = 0; ws < 4; ws++) begin
      int wl, dv, pat;
      wl = wl_of(ws[1:0]);
      dv = ws + 1;
      pat = (ws == 0) ? 32'hA5 : (ws == 1) ? 32'hC3B : (ws == 2) ? 32'h9E71 : 32'hAA0F35;
      do_reset(1, ws[1:0], dv[7:0]);
      write_word(pat | 32'h0100_0000);
      idle_wait();
      check(pulses == wl, "R4 R7 pulse count", pulses, wl);
      check(cap == pat, "R5 msb first word", cap, pat);
      check(fs_rises == 1, "R6 one fsync", fs_rises, 1);
      check(fs_high == 2 * (dv + 1), "R6 fsync width", fs_high, 2 * (dv + 1));
      check(sdata == 0, "R11 idle data", sdata, 0);
    end

    // R8 R9 back-to-back gated words
    do_reset(1, 2'b00, 8'd0);
    b2b = 1;
    write_word(32'h3C);
    check(tx_empty == 0, "R9 held", tx_empty, 0);
    write_word(32'hF0);
    write_word(32'h81);
    idle_wait();
    check(pulses == 24, "R8 three words", pulses, 24);
    check(cap == 32'h3CF081, "R8 stream", cap, 32'h3CF081);
    b2b = 0;

    // R9 R10 collision: second write lost, first sent
    do_reset(1, 2'b00, 8'd2);
    @(negedge clk);
    wr_en = 1; wr_data = 24'h5A;
    @(negedge clk);
    wr_data = 24'hFF;
    @(negedge clk);
    wr_en = 0;
    check(wr_collision == 1, "R10 collision set", wr_collision, 1);
    idle_wait();
    check(cap == 32'h5A, "R10 ignored write", cap, 32'h5A);
    write_word(32'h11);
    idle_wait();
    check(wr_collision == 1, "R10 sticky", wr_collision, 1);

    // R3 R6 continuous clock
    do_reset(0, 2'b01, 8'd3);
    repeat (60) @(negedge clk);
    check(pulses > 5, "R3 free clock", pulses, 7);
    check(fs_rises == 0, "R6 no fsync idle", fs_rises, 0);
    write_word(32'h7E5);
    write_word(32'h00F);
    idle_wait();
    check(fs_rises == 2, "R6 fsync per word", fs_rises, 2);
    check(fs_high == 2 * 2 * 4, "R6 fsync widths", fs_high, 16);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule